// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the control strobes that an 8-bit microcontroller drives onto a multiplexed address/data bus. A free-running phase counter, clocked by the oscillator, divides time into machine cycles of twelve oscillator periods. Each half of a machine cycle opens with an address-latch pulse. When the core executes from external code memory, a short code-read strobe follows each latch pulse, so two code bytes are read per machine cycle. When it executes from internal memory, the latch pulses continue but the code-read strobe stays idle.

A data move to or from external memory is requested with `move_req` and its direction with `move_wr`. The request is sampled only at a machine-cycle boundary. The machine cycle that follows is a data cycle. It keeps its first latch pulse so the data address can be captured. A six-period read or write strobe replaces the code-read strobes, and the latch pulse that would fall inside that strobe is dropped. A combined active-low read strobe lets a single memory serve both code and data reads. It is low whenever either the code-read strobe or the data-read strobe is low.

All outputs are registered. Each output shows the decode of the phase that the counter held one clock earlier.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: While `rst_n` is low, and up to the first clock edge after its release, `ale` and `addr_lo_oe` are 0 and `psen_n`, `rd_n`, `wr_n` and `shared_rd_n` are 1. The phase counter restarts at 0.
- R2: The phase counter cycles 0..11, one step per clock. In a cycle that is not a data cycle, `ale` is high for 2 periods at phases 0, 1, 6 and 7. This gives one pulse every 6 periods, whether or not the code fetch is external.
- R3: In an external-fetch cycle, `psen_n` is low for 3 periods at phases 3..5 and again at phases 9..11. That is two code reads per machine cycle.
- R4: In an internal-fetch cycle, `psen_n` stays high for all 12 phases.
- R5: `addr_lo_oe` is high during each latch pulse and for one period after it, so the low address byte is still driven when `ale` falls. In an external-fetch cycle this covers phases 0..2 and 6..8. In a data cycle it covers phases 0..2. In an internal-fetch cycle it stays low.
- R6: `move_req`, `move_wr` and `fetch_ext` are sampled only in the period when the counter holds phase 11, and they set the kind of the next machine cycle. A `move_req` pulse that ends before that period has no effect.
- R7: In a data cycle, exactly one of `rd_n` (when `move_wr`=0) or `wr_n` (when `move_wr`=1) is low, for 6 periods at phases 3..8. The two strobes are never low together.
- R8: In a data cycle, `psen_n` stays high for all 12 phases and the latch pulse at phases 6..7 is suppressed. Only the pulse at phases 0..1 remains.
- R9: `shared_rd_n` is the AND of `psen_n` and `rd_n`. It is low exactly when either of them is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_ext | input | 1 | 1: code is fetched from external memory; 0: from internal memory |
| move_req | input | 1 | Request an external data move in the next machine cycle |
| move_wr | input | 1 | Direction of the data move: 1 write, 0 read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data-read strobe, active low |
| wr_n | output | 1 | Data-write strobe, active low |
| addr_lo_oe | output | 1 | Output enable for the low address byte on the multiplexed port |
| shared_rd_n | output | 1 | Combined code/data read strobe, active low |

## Verification
The hardest case to reach from the ports is a data-move request that comes and goes in the middle of a machine cycle. It has to leave no trace, while a request present at phase 11 must turn the whole next cycle into a data cycle. The stimulus keeps its own count of clock edges since reset. It uses that count to place a short `move_req` pulse at phases 2..3 and then checks a full cycle of ordinary fetch strobes. It also holds a request across the boundary and drops it one period later, so that exactly one data cycle follows.

// File: rtl/bus_strobe_pkg.sv
// Package: shared types for the external bus strobe sequencer.
// Assumes: one machine cycle is decoded as a single kind, fixed at its start.
package bus_strobe_pkg;

    // Kind of machine cycle, chosen at each cycle boundary.
    typedef enum logic [1:0] {
        CYC_INTERNAL = 2'd0,
        CYC_EXTERNAL = 2'd1,
        CYC_DATA_RD  = 2'd2,
        CYC_DATA_WR  = 2'd3
    } cyc_kind_e;

    // Packed view of the strobe outputs, all registered together.
    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic addr_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                        wr_n: 1'b1, addr_oe: 1'b0};

endpackage

// File: rtl/strb_phase_ctr.sv
// Module: free-running phase counter for the strobe sequencer.
// Counts 0..PHASES-1 once per oscillator clock and flags the last phase.
// Assumes: synchronous active-low reset, which restarts the count at 0.
module strb_phase_ctr #(
    parameter int PHASES = 12,
    localparam int PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last_phase
);

    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic [PW-1:0] phase_q;

    // Advance the phase, wrapping at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign phase      = phase_q;
    assign last_phase = (phase_q == LAST);

endmodule

// File: rtl/strb_cycle_latch.sv
// Module: picks the kind of the next machine cycle.
// Samples the request inputs only while the counter holds the last phase.
// Assumes: a data move takes priority over the fetch kind for that cycle.
module strb_cycle_latch
    import bus_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      last_phase,
    input  logic      fetch_ext,
    input  logic      move_req,
    input  logic      move_wr,
    output cyc_kind_e kind
);

    cyc_kind_e kind_q;
    cyc_kind_e kind_next;

    // Work out the kind from the sampled inputs.
    always_comb begin
        if (move_req)
            kind_next = move_wr ? CYC_DATA_WR : CYC_DATA_RD;
        else
            kind_next = fetch_ext ? CYC_EXTERNAL : CYC_INTERNAL;
    end

    // Hold the kind for a whole machine cycle; update only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_q <= CYC_INTERNAL;
        else if (last_phase)
            kind_q <= kind_next;
    end

    assign kind = kind_q;

endmodule

// File: rtl/strb_decode.sv
// Module: turns the phase and the cycle kind into registered strobes.
// The outputs show the decode of the phase held one clock earlier.
// Assumes: PHASES is even; both halves of the cycle share one timing pattern.
module strb_decode
    import bus_strobe_pkg::*;
#(
    parameter int PHASES      = 12,
    parameter int ALE_W       = 2,
    parameter int FETCH_START = 3,
    parameter int MOVE_START  = 3,
    parameter int MOVE_LEN    = 6,
    localparam int PW         = $clog2(PHASES),
    localparam int HALF       = PHASES / 2,
    localparam int OE_LEN     = ALE_W + 1,
    localparam int MOVE_END   = MOVE_START + MOVE_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  cyc_kind_e     kind,
    output strobe_t       strobes
);

    strobe_t nxt;
    strobe_t strobes_q;

    // Decode the strobe levels for the current phase and cycle kind.
    always_comb begin
        int  ph;
        int  sub;
        logic is_data;
        logic in_move;
        ph      = int'(phase);
        sub     = ph % HALF;
        is_data = (kind == CYC_DATA_RD) || (kind == CYC_DATA_WR);
        in_move = (ph >= MOVE_START) && (ph < MOVE_END);
        nxt     = STROBE_IDLE;
        nxt.ale = (sub < ALE_W) && !(is_data && in_move);
        unique case (kind)
            CYC_EXTERNAL: begin
                nxt.psen_n  = !(sub >= FETCH_START);
                nxt.addr_oe = (sub < OE_LEN);
            end
            CYC_DATA_RD: begin
                nxt.rd_n    = !in_move;
                nxt.addr_oe = (ph < OE_LEN);
            end
            CYC_DATA_WR: begin
                nxt.wr_n    = !in_move;
                nxt.addr_oe = (ph < OE_LEN);
            end
            default: ;
        endcase
    end

    // Register all strobes together so they leave the block without glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobes_q <= STROBE_IDLE;
        else
            strobes_q <= nxt;
    end

    assign strobes = strobes_q;

endmodule

// File: rtl/ext_bus_strobe_seq.sv
// Module: external bus strobe sequencer (top).
// Generates the address-latch, code-read, data-read/write and shared read
// strobes for a multiplexed bus from a twelve-phase machine cycle.
// Assumes: clk is the oscillator clock and rst_n is synchronous, active low.
module ext_bus_strobe_seq
    import bus_strobe_pkg::*;
#(
    parameter int PHASES      = 12,
    parameter int ALE_W       = 2,
    parameter int FETCH_START = 3,
    parameter int MOVE_START  = 3,
    parameter int MOVE_LEN    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_ext,
    input  logic move_req,
    input  logic move_wr,
    output logic ale,
    output logic psen_n,
    output logic rd_n,
    output logic wr_n,
    output logic addr_lo_oe,
    output logic shared_rd_n
);

    localparam int PW = $clog2(PHASES);

    logic [PW-1:0] phase;
    logic          last_phase;
    cyc_kind_e     kind;
    strobe_t       strobes;

    strb_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_phase (last_phase)
    );

    strb_cycle_latch u_kind (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_phase (last_phase),
        .fetch_ext  (fetch_ext),
        .move_req   (move_req),
        .move_wr    (move_wr),
        .kind       (kind)
    );

    strb_decode #(
        .PHASES      (PHASES),
        .ALE_W       (ALE_W),
        .FETCH_START (FETCH_START),
        .MOVE_START  (MOVE_START),
        .MOVE_LEN    (MOVE_LEN)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .kind    (kind),
        .strobes (strobes)
    );

    assign ale         = strobes.ale;
    assign psen_n      = strobes.psen_n;
    assign rd_n        = strobes.rd_n;
    assign wr_n        = strobes.wr_n;
    assign addr_lo_oe  = strobes.addr_oe;
    // Shared memory read: low when either the code or the data read is low.
    assign shared_rd_n = strobes.psen_n & strobes.rd_n;

endmodule

// File: rtl/ext_bus_strobe_seq_chk.sv
// Module: assertion checker for the external bus strobe sequencer.
// Observes the top-level strobes only; attached with bind below.
// Assumes: ALE_W is at least 2 in the checked configuration.
module ext_bus_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic addr_lo_oe,
    input logic shared_rd_n
);

    // R2: a latch pulse lasts at least two periods.
    p_ale_two_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale);

    // R5: the address stays driven for the period in which ale falls.
    p_addr_over_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && addr_lo_oe) |=> addr_lo_oe);

    // R7: read and write strobes are never low together.
    p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8: while a data strobe is low, the code strobe and latch stay idle.
    p_move_quiets_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (psen_n && !ale));

    // R9: the shared read goes low only when one of its sources is low.
    p_shared_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_rd_n |-> (!psen_n || !rd_n));

    // R9: a data read always shows on the shared read.
    p_shared_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !shared_rd_n);

endmodule

bind ext_bus_strobe_seq ext_bus_strobe_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ale         (ale),
    .psen_n      (psen_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr_lo_oe  (addr_lo_oe),
    .shared_rd_n (shared_rd_n)
);

// File: tb/ext_bus_strobe_seq_bench.sv
// Bench: directed scenarios for the external bus strobe sequencer.
// Counts clock edges since reset; the inputs present at every edge whose
// count is a multiple of 12 set the kind of the next machine cycle.
module ext_bus_strobe_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_ext = 1'b0;
    logic move_req = 1'b0;
    logic move_wr = 1'b0;
    logic ale, psen_n, rd_n, wr_n, addr_lo_oe, shared_rd_n;

    int checks = 0;
    int errors = 0;
    int ecount = 0;

    localparam int K_INT = 0;
    localparam int K_EXT = 1;
    localparam int K_RD  = 2;
    localparam int K_WR  = 3;

    always #2 clk = ~clk;

    ext_bus_strobe_seq u_ext_bus_strobe_seq (
        .clk(clk), .rst_n(rst_n), .fetch_ext(fetch_ext), .move_req(move_req),
        .move_wr(move_wr), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr_lo_oe(addr_lo_oe), .shared_rd_n(shared_rd_n)
    );

    // Count edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    // Expected {ale, psen_n, rd_n, wr_n, addr_lo_oe, shared_rd_n} from the requirements.
    function automatic logic [5:0] expect_vec(input int p, input int k);
        int q;
        logic e_ale, e_psen, e_rd, e_wr, e_oe;
        logic data;
        logic win;
        q      = p % 6;
        data   = (k == K_RD) || (k == K_WR);
        win    = (p >= 3) && (p <= 8);
        e_ale  = (q < 2) && !(data && win);
        e_psen = !((k == K_EXT) && (q >= 3));
        e_rd   = !((k == K_RD) && win);
        e_wr   = !((k == K_WR) && win);
        e_oe   = (k == K_EXT) ? (q < 3) : (data ? (p < 3) : 1'b0);
        return {e_ale, e_psen, e_rd, e_wr, e_oe, e_psen & e_rd};
    endfunction

    task automatic check_vec(input string req, input int p, input logic [5:0] exp_v);
        logic [5:0] act;
        act = {ale, psen_n, rd_n, wr_n, addr_lo_oe, shared_rd_n};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s phase %0d actual %b expected %b", req, p, act, exp_v);
        end
    endtask

    // Wait, at a negedge, for the next edge that latches the cycle kind.
    task automatic to_boundary();
        @(negedge clk);
        while ((ecount % 12) != 0) @(negedge clk);
    endtask

    // Check the twelve phases of the machine cycle that just began.
    task automatic check_cycle(input string req, input int k);
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            check_vec(req, p, expect_vec(p, k));
        end
    endtask

    // R1: reset state and the first (internal) cycle after release.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_vec("R1 in reset", 0, 6'b011101);
        rst_n = 1'b1;
        check_vec("R1 after release", 0, 6'b011101);
        check_cycle("R1 R2 first cycle", K_INT);
    endtask

    // R2 R4: internal fetch keeps ale running and psen_n idle.
    task automatic t_internal();
        fetch_ext = 1'b0;
        to_boundary();
        check_cycle("R2 R4 internal", K_INT);
    endtask

    // R3 R5: external fetch, two code reads per cycle.
    task automatic t_external();
        fetch_ext = 1'b1;
        to_boundary();
        check_cycle("R3 R5 external", K_EXT);
        check_cycle("R3 R5 external back-to-back", K_EXT);
    endtask

    // R7 R8 R9: one data cycle in either direction, then back to fetching.
    task automatic t_move(input logic wr, input string req);
        fetch_ext = 1'b1;
        move_wr   = wr;
        move_req  = 1'b1;
        to_boundary();
        move_req  = 1'b0;
        check_cycle(req, wr ? K_WR : K_RD);
        check_cycle("R6 one data cycle only", K_EXT);
    endtask

    // R6: a request pulse away from the boundary is ignored.
    task automatic t_ignored();
        fetch_ext = 1'b1;
        to_boundary();
        check_cycle("R6 lead-in", K_EXT);
        repeat (2) @(negedge clk);
        move_req = 1'b1;
        move_wr  = 1'b0;
        repeat (2) @(negedge clk);
        move_req = 1'b0;
        while ((ecount % 12) != 0) @(negedge clk);
        check_cycle("R6 mid-cycle pulse ignored", K_EXT);
    endtask

    // Mode change from data write straight into internal fetch.
    task automatic t_move_to_internal();
        fetch_ext = 1'b0;
        move_wr   = 1'b1;
        move_req  = 1'b1;
        to_boundary();
        move_req  = 1'b0;
        check_cycle("R7 R8 write from internal", K_WR);
        check_cycle("R4 internal after move", K_INT);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_external();
        t_move(1'b0, "R7 R8 R9 data read");
        t_move(1'b1, "R7 R8 R9 data write");
        t_ignored();
        t_move_to_internal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule